// File: doc/BRIEF.md
# Segmented Scan and Reduction Unit

This unit takes a stream of 32-bit integer elements, one per cycle, and turns it into one of three kinds of results: one total for the whole vector, an exclusive running sum, or an exclusive running sum that restarts at segment boundaries. Each element has a participate flag and a segment-start flag. A last marker closes the vector. A vector may be any length from one element upward.

The mode input is taken on the first element that is accepted for a vector. That choice holds until the element marked last has been accepted. In the two scan modes, each accepted element produces exactly one output item, in input order. In total mode, only the last element produces an output. Both the input and the output use a valid/ready handshake. One output register sits between them, so a stalled consumer holds back the input.

Top module: `seg_scan_unit`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid_o` is low and `in_ready_o` is high until the first element is accepted.
- R2: With mode 2'b00 (total), the element marked last produces one output item. Its value is the 32-bit sum of all participating elements of the vector. No other element of that vector produces an output item.
- R3: With mode 2'b01 (plain scan), each element produces one output item. Its value is the sum of the participating elements that came before it in the same vector, with the element itself excluded. The first element outputs 0, and segment-start flags have no effect.
- R4: With mode 2'b10 or 2'b11 (segmented scan), the running sum restarts at every element whose segment-start flag is 1. That element outputs 0. Every other element outputs the sum of the participating elements before it since the most recent restart.
- R5: An element whose participate flag is 0 adds nothing to any sum. In the scan modes it still produces an output item, which carries the current running sum.
- R6: All sums are 32 bits wide and wrap around modulo 2^32.
- R7: The mode is sampled on the first accepted element of a vector. Changes on `mode_i` while that vector is in progress have no effect.
- R8: After the element marked last is accepted, the running sum is cleared, so the next vector starts from 0.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the output item is held unchanged and `in_ready_o` is low.
- R10: `out_last_o` is 1 exactly on the output item produced by an element marked last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 total, 01 plain scan, 1x segmented scan |
| in_valid_i | input | 1 | Input element present |
| in_ready_o | output | 1 | Unit can accept an element |
| in_data_i | input | 32 | Element value |
| in_seg_start_i | input | 1 | Element opens a new segment |
| in_ctx_i | input | 1 | Element participates in sums |
| in_last_i | input | 1 | Element closes the vector |
| out_valid_o | output | 1 | Output item present |
| out_ready_i | input | 1 | Consumer takes the output item |
| out_data_o | output | 32 | Total or exclusive running sum |
| out_last_o | output | 1 | Item belongs to the last element |

## Verification
The stimulus feeds in these vectors:
- A plain scan with segment flags set, which shows that the flags are ignored outside segmented mode.
- A segmented scan with restarts at the start and in the middle, which separates restart handling from plain accumulation.
- Mixes of participating and non-participating elements in both scan and total modes, which show that excluded elements keep their output slot but add nothing.
- Near-overflow values, which expose a missing wrap.
- Single-element vectors, which catch an off-by-one in the first and last handling.
- A vector during which `mode_i` changes, which tells sampling on the first element apart from live decoding.

A stuttering output-ready pattern and one long stall check that results stay in order and are held while stalled.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

  localparam int unsigned SUM_W  = 32;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_TOTAL   = 2'b00,
    MODE_SCAN    = 2'b01,
    MODE_SEG     = 2'b10,
    MODE_SEG_ALT = 2'b11
  } scan_mode_e;

  function automatic logic mode_is_total(input logic [MODE_W-1:0] m);
    return m == MODE_TOTAL;
  endfunction

  function automatic logic mode_is_seg(input logic [MODE_W-1:0] m);
    return m[MODE_W-1];
  endfunction

  // value an element adds to the running sum
  function automatic logic [SUM_W-1:0] elem_share(input logic [SUM_W-1:0] d,
                                                  input logic ctx);
    return ctx ? d : '0;
  endfunction

  // running sum seen by an element before its own share
  function automatic logic [SUM_W-1:0] start_sum(input logic [SUM_W-1:0] acc,
                                                 input logic restart);
    return restart ? '0 : acc;
  endfunction

  function automatic logic [SUM_W-1:0] wrap_add(input logic [SUM_W-1:0] a,
                                                input logic [SUM_W-1:0] b);
    return a + b;
  endfunction

endpackage

// File: rtl/seg_scan_ctrl.sv
module seg_scan_ctrl
  import seg_scan_pkg::*;
#(
  parameter int unsigned MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire_i,
  input  logic          last_i,
  input  logic [MW-1:0] mode_i,
  output logic          first_o,
  output logic [MW-1:0] mode_o,
  output logic [MW-1:0] mode_q_o
);

  logic          open_q;
  logic [MW-1:0] mode_q;

  assign first_o  = !open_q;
  assign mode_o   = open_q ? mode_q : mode_i;
  assign mode_q_o = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      mode_q <= '0;
    end else if (fire_i) begin
      open_q <= !last_i;
      if (!open_q) mode_q <= mode_i;
    end
  end

endmodule

// File: rtl/seg_scan_accum.sv
module seg_scan_accum
  import seg_scan_pkg::*;
#(
  parameter int unsigned W = SUM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire_i,
  input  logic         restart_i,
  input  logic         ctx_i,
  input  logic         last_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] before_o,
  output logic [W-1:0] incl_o,
  output logic [W-1:0] acc_o
);

  logic [W-1:0] acc_q;

  assign before_o = start_sum(acc_q, restart_i);
  assign incl_o   = wrap_add(before_o, elem_share(data_i, ctx_i));
  assign acc_o    = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (fire_i) acc_q <= last_i ? '0 : incl_o;
  end

endmodule

// File: rtl/seg_scan_outreg.sv
module seg_scan_outreg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         last_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         last_o,
  output logic         room_o
);

  logic         vld_q;
  logic [W-1:0] dat_q;
  logic         lst_q;

  assign room_o  = !vld_q || ready_i;
  assign valid_o = vld_q;
  assign data_o  = dat_q;
  assign last_o  = lst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
      lst_q <= 1'b0;
    end else if (load_i) begin
      vld_q <= 1'b1;
      dat_q <= data_i;
      lst_q <= last_i;
    end else if (ready_i) begin
      vld_q <= 1'b0;
    end
  end

endmodule

// File: rtl/seg_scan_unit.sv
module seg_scan_unit
  import seg_scan_pkg::*;
#(
  parameter int unsigned DATA_W = SUM_W,
  parameter int unsigned MSEL_W = MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MSEL_W-1:0] mode_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_seg_start_i,
  input  logic              in_ctx_i,
  input  logic              in_last_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o
);

  // named internal events
  logic              in_fire;
  logic              first_w;
  logic [MSEL_W-1:0] mode_w;
  logic [MSEL_W-1:0] mode_q_w;
  logic              restart_w;
  logic              emit_w;
  logic [DATA_W-1:0] before_w;
  logic [DATA_W-1:0] incl_w;
  logic [DATA_W-1:0] acc_w;
  logic [DATA_W-1:0] result_w;
  logic              room_w;

  assign in_ready_o = room_w;
  assign in_fire    = in_valid_i && room_w;
  assign restart_w  = first_w || (mode_is_seg(mode_w) && in_seg_start_i);
  assign emit_w     = in_fire && (!mode_is_total(mode_w) || in_last_i);
  assign result_w   = mode_is_total(mode_w) ? incl_w : before_w;

  seg_scan_ctrl #(.MW(MSEL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_i   (in_fire),
    .last_i   (in_last_i),
    .mode_i   (mode_i),
    .first_o  (first_w),
    .mode_o   (mode_w),
    .mode_q_o (mode_q_w)
  );

  seg_scan_accum #(.W(DATA_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (in_fire),
    .restart_i (restart_w),
    .ctx_i     (in_ctx_i),
    .last_i    (in_last_i),
    .data_i    (in_data_i),
    .before_o  (before_w),
    .incl_o    (incl_w),
    .acc_o     (acc_w)
  );

  seg_scan_outreg #(.W(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (emit_w),
    .data_i  (result_w),
    .last_i  (in_last_i),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .data_o  (out_data_o),
    .last_o  (out_last_o),
    .room_o  (room_w)
  );

endmodule

// File: rtl/seg_scan_checker.sv
module seg_scan_checker #(
  parameter int unsigned DW = 32,
  parameter int unsigned MW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_fire,
  input logic          first_w,
  input logic [MW-1:0] mode_w,
  input logic [MW-1:0] mode_q_w,
  input logic          in_seg_start_i,
  input logic          in_last_i,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [DW-1:0] out_data_o,
  input logic [DW-1:0] acc_w
);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  p_first_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && first_w && (mode_w != 2'b00) |=> out_valid_o && (out_data_o == '0));

  p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && mode_w[MW-1] && in_seg_start_i |=> out_valid_o && (out_data_o == '0));

  p_total_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && (mode_w == 2'b00) && !in_last_i |=> !out_valid_o);

  p_mode_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && !in_last_i |=> mode_q_w == $past(mode_w));

  p_sum_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_last_i |=> acc_w == '0);

endmodule

bind seg_scan_unit seg_scan_checker #(.DW(DATA_W), .MW(MSEL_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_fire        (in_fire),
  .first_w        (first_w),
  .mode_w         (mode_w),
  .mode_q_w       (mode_q_w),
  .in_seg_start_i (in_seg_start_i),
  .in_last_i      (in_last_i),
  .out_valid_o    (out_valid_o),
  .out_ready_i    (out_ready_i),
  .out_data_o     (out_data_o),
  .acc_w          (acc_w)
);

// File: tb/seg_scan_unit_bench.sv
module seg_scan_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_data_i = '0;
  logic        in_seg_start_i = 1'b0;
  logic        in_ctx_i = 1'b0;
  logic        in_last_i = 1'b0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] out_data_o;
  logic        out_last_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int rdy_mode = 0;  // 0 always ready, 1 stutter, 2 stalled
  int rdy_cnt  = 0;

  logic [31:0] exp_d[$];
  bit          exp_l[$];
  string       exp_t[$];

  // bench reference state
  bit          bm_open = 1'b0;
  logic [1:0]  bm_mode = 2'b00;
  logic [31:0] bm_run  = '0;

  always #4 clk = ~clk;

  seg_scan_unit u_seg_scan_unit (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_i         (mode_i),
    .in_valid_i     (in_valid_i),
    .in_ready_o     (in_ready_o),
    .in_data_i      (in_data_i),
    .in_seg_start_i (in_seg_start_i),
    .in_ctx_i       (in_ctx_i),
    .in_last_i      (in_last_i),
    .out_valid_o    (out_valid_o),
    .out_ready_i    (out_ready_i),
    .out_data_o     (out_data_o),
    .out_last_o     (out_last_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // consumer ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    #2;
    rdy_cnt++;
    case (rdy_mode)
      0:       out_ready_i = 1'b1;
      1:       out_ready_i = (rdy_cnt % 4) != 3;
      default: out_ready_i = 1'b0;
    endcase
  end

  // driver: model the expected item, then hand the element over
  task automatic send(input logic [31:0] d, input bit ctx, input bit sg,
                      input bit lst, input logic [1:0] m, input string tag);
    logic [31:0] base;
    logic [31:0] nv;
    if (!bm_open) bm_mode = m;
    if (!bm_open || (bm_mode[1] && sg)) base = '0;
    else base = bm_run;
    nv = base + (ctx ? d : 32'h0);
    if (bm_mode != 2'b00) begin
      exp_d.push_back(base); exp_l.push_back(lst); exp_t.push_back(tag);
    end else if (lst) begin
      exp_d.push_back(nv); exp_l.push_back(1'b1); exp_t.push_back(tag);
    end
    bm_run  = lst ? 32'h0 : nv;
    bm_open = !lst;
    mode_i = m; in_data_i = d; in_ctx_i = ctx; in_seg_start_i = sg;
    in_last_i = lst; in_valid_i = 1'b1;
    while (!in_ready_o) @(negedge clk);
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  // monitor: compare every transferred item against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid_o && out_ready_i) begin
      if (exp_d.size() == 0) begin
        check(1'b0, "R2 unexpected item", out_data_o, 32'h0);
      end else begin
        logic [31:0] ed;
        bit el;
        string et;
        ed = exp_d.pop_front(); el = exp_l.pop_front(); et = exp_t.pop_front();
        check(out_data_o == ed, et, out_data_o, ed);
        check(out_last_o == el, {et, " R10 last flag"}, {31'h0, out_last_o}, {31'h0, el});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid_o == 1'b0, "R1 valid in reset", {31'h0, out_valid_o}, 32'h0);
    check(in_ready_o == 1'b1, "R1 ready in reset", {31'h0, in_ready_o}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid_o == 1'b0, "R1 valid after reset", {31'h0, out_valid_o}, 32'h0);

    // R3: plain scan, segment flags ignored
    send(1, 1, 0, 0, 2'b01, "R3 scan");
    send(2, 1, 0, 0, 2'b01, "R3 scan");
    send(3, 1, 1, 0, 2'b01, "R3 scan seg ignored");
    send(4, 1, 0, 0, 2'b01, "R3 scan");
    send(5, 1, 0, 1, 2'b01, "R3 scan");
    // R4: segmented with restarts
    send(10, 1, 1, 0, 2'b10, "R4 seg");
    send(20, 1, 0, 0, 2'b10, "R4 seg");
    send(30, 1, 1, 0, 2'b10, "R4 seg restart");
    send(40, 1, 0, 0, 2'b10, "R4 seg");
    send(50, 1, 1, 0, 2'b11, "R4 seg restart");
    send(60, 1, 0, 1, 2'b11, "R4 seg");
    rdy_mode = 1;
    // R5: non-participating elements in scan
    send(7, 1, 0, 0, 2'b01, "R5 ctx");
    send(100, 0, 0, 0, 2'b01, "R5 ctx");
    send(8, 1, 0, 0, 2'b01, "R5 ctx");
    send(200, 0, 0, 0, 2'b01, "R5 ctx");
    send(9, 1, 0, 1, 2'b01, "R5 ctx");
    // R2: total with mixed participation
    send(11, 1, 0, 0, 2'b00, "R2 total");
    send(500, 0, 1, 0, 2'b00, "R2 total");
    send(22, 1, 0, 0, 2'b00, "R2 total");
    send(33, 1, 0, 1, 2'b00, "R2 total");
    // R6: wrap in total and scan
    send(32'hFFFF_FFFF, 1, 0, 0, 2'b00, "R6 wrap total");
    send(32'h0000_0003, 1, 0, 1, 2'b00, "R6 wrap total");
    send(32'hFFFF_FFFE, 1, 0, 0, 2'b01, "R6 wrap scan");
    send(32'h0000_0005, 1, 0, 0, 2'b01, "R6 wrap scan");
    send(32'h0000_0001, 1, 0, 1, 2'b01, "R6 wrap scan");
    // R7: mode changes mid-vector
    send(1, 1, 0, 0, 2'b01, "R7 mode held");
    send(2, 1, 1, 0, 2'b00, "R7 mode held");
    send(3, 1, 1, 1, 2'b10, "R7 mode held");
    send(4, 1, 1, 0, 2'b00, "R7 mode held");
    send(5, 1, 0, 1, 2'b10, "R7 mode held");
    // R8: single-element vectors start fresh
    send(77, 1, 0, 1, 2'b01, "R8 fresh");
    send(88, 1, 0, 1, 2'b00, "R8 fresh total");
    send(99, 0, 0, 1, 2'b00, "R8 fresh total excluded");
    send(5, 1, 0, 0, 2'b10, "R8 fresh");
    send(6, 1, 0, 1, 2'b10, "R8 fresh");

    // R9: long stall holds the item and blocks input
    repeat (8) @(negedge clk);
    rdy_mode = 2;
    repeat (2) @(negedge clk);
    send(123, 1, 0, 1, 2'b01, "R9 stalled item");
    check(out_valid_o == 1'b1, "R9 valid while stalled", {31'h0, out_valid_o}, 32'h1);
    check(in_ready_o == 1'b0, "R9 ready low while stalled", {31'h0, in_ready_o}, 32'h0);
    repeat (3) @(negedge clk);
    check(out_valid_o == 1'b1, "R9 still valid", {31'h0, out_valid_o}, 32'h1);
    check(out_data_o == 32'h0, "R9 data held", out_data_o, 32'h0);
    check(in_ready_o == 1'b0, "R9 ready still low", {31'h0, in_ready_o}, 32'h0);
    rdy_mode = 0;

    repeat (40) begin
      if (exp_d.size() != 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check(exp_d.size() == 0, "R2 all items delivered", exp_d.size(), 32'h0);
    check(out_valid_o == 1'b0, "R2 no extra item", {31'h0, out_valid_o}, 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule